// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Per-Pin Edge Interrupts

This block is a 16-pin general-purpose I/O port behind a small register bus. Each pin can be an input or an output. Output pins drive a latched value onto their pad. Input pins pass through a two-flop synchronizer. A synchronized input can raise an interrupt on its rising or its falling edge, and each pin chooses one of the two with its own polarity bit.

Software talks to the port through a bus with a valid strobe, a write flag, a size code, a byte address and 16-bit write data. The block accepts only halfword accesses. Read data is combinational and valid in the same cycle as the read request. Interrupt status bits stay set until software writes a one to them. The single interrupt output is high while any status bit is set.

Top module: `gpio_edge16`

## Requirements
- R1: Registers sit at these byte offsets: 0x04 output latch, 0x08 direction, 0x0C edge polarity, 0x10 interrupt mask, 0x14 interrupt status, 0x18 pin enable. Each of them reads back its value. A read of any offset outside 0x00–0x18 returns zero, and a write to such an offset changes nothing. When no halfword read is in progress, `bus_rdata` is zero.
- R2: Offset 0x00 reads the synchronized inputs ANDed with the pin-enable register. A pin change set up before clock edge k shows up in this read after edge k+1 and not before.
- R3: A status bit is latched only when its direction bit is 1 (input) and its mask bit is 0. It is latched on a rising synchronized transition when the polarity bit is 1, and on a falling transition when the polarity bit is 0. A pin change set up before edge k is readable in status after edge k+2.
- R4: A write to 0x14 clears every status bit written as one and leaves the other bits alone. A bit that is newly latched in the same cycle stays set.
- R5: `irq` is high exactly when at least one status bit is set.
- R6: `pad_en[i]` is the inverse of direction bit i. `pad_out[i]` equals the output latch bit when direction bit i is 0, and is 0 otherwise. A change of direction to output drives the latched value from the next cycle.
- R7: After reset, the output latch, direction, polarity, mask and pin-enable registers are all ones. The synchronized inputs and the status register are zero.
- R8: An access whose size code is not 1 (halfword; 0 is byte, 2 is word) changes no register and reads as zero.
- R9: A write to the input register at 0x00 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle |
| pin_in | input | 16 | Asynchronous pin levels |
| pad_out | output | 16 | Pad drive value |
| pad_en | output | 16 | Pad output enable |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle: a newly latched status bit must have had its pin set as an unmasked input in the cycle before, and `irq` may fall only right after a status write. Accesses with the wrong size and writes to the input register must leave every configuration register unchanged. Pads of input pins must never be driven high, and idle read data must be zero. Other behaviour can only be shown by the bench's scenarios. These are the choice of edge by each polarity bit, the two-cycle latency to the input read and the extra cycle to status, the masking of input reads by the pin enable, and set-versus-clear collisions under random pin activity. In these scenarios a behavioural model is compared against the outputs on every clock.

// File: rtl/gpio_edge16.sv
module gpio_edge16 #(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_en,
  output logic          irq
);
  localparam logic [1:0]    SZ_HALF = 2'd1;
  localparam logic [AW-1:0] A_IN   = AW'('h00);
  localparam logic [AW-1:0] A_OUT  = AW'('h04);
  localparam logic [AW-1:0] A_DIR  = AW'('h08);
  localparam logic [AW-1:0] A_POL  = AW'('h0C);
  localparam logic [AW-1:0] A_MASK = AW'('h10);
  localparam logic [AW-1:0] A_STAT = AW'('h14);
  localparam logic [AW-1:0] A_PEN  = AW'('h18);

  logic [W-1:0] sync_a, sync_b, sync_prev;
  logic [W-1:0] out_q, dir_q, pol_q, mask_q, stat_q, pen_q;
  logic [W-1:0] rise, fall, hit, clr;
  logic         acc_ok, wr, rd;

  assign acc_ok = bus_valid && (bus_size == SZ_HALF);
  assign wr     = acc_ok && bus_write;
  assign rd     = acc_ok && !bus_write;

  assign rise = sync_b & ~sync_prev;
  assign fall = ~sync_b & sync_prev;
  assign hit  = ((rise & pol_q) | (fall & ~pol_q)) & dir_q & ~mask_q;
  assign clr  = (wr && bus_addr == A_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a    <= '0;
      sync_b    <= '0;
      sync_prev <= '0;
    end else begin
      sync_a    <= pin_in;
      sync_b    <= sync_a;
      sync_prev <= sync_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '1;
      dir_q  <= '1;
      pol_q  <= '1;
      mask_q <= '1;
      pen_q  <= '1;
    end else if (wr) begin
      case (bus_addr)
        A_OUT:   out_q  <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_POL:   pol_q  <= bus_wdata;
        A_MASK:  mask_q <= bus_wdata;
        A_PEN:   pen_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | hit;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        A_IN:    bus_rdata = sync_b & pen_q;
        A_OUT:   bus_rdata = out_q;
        A_DIR:   bus_rdata = dir_q;
        A_POL:   bus_rdata = pol_q;
        A_MASK:  bus_rdata = mask_q;
        A_STAT:  bus_rdata = stat_q;
        A_PEN:   bus_rdata = pen_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pad_en  = ~dir_q;
  assign pad_out = out_q & ~dir_q;
  assign irq     = |stat_q;
endmodule

// File: rtl/gpio_edge16_chk.sv
module gpio_edge16_chk #(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [1:0]    bus_size,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  pad_out,
  input logic [W-1:0]  pad_en,
  input logic          irq,
  input logic [W-1:0]  stat,
  input logic [W-1:0]  dir,
  input logic [W-1:0]  mask,
  input logic [W-1:0]  outq,
  input logic [W-1:0]  polq,
  input logic [W-1:0]  pen
);
  p_new_stat_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~$past(stat)) & ~($past(dir) & ~$past(mask))) == '0);

  p_irq_falls_on_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_valid && bus_write && bus_size == 2'd1 && bus_addr == AW'('h14)));

  p_bad_size_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_size != 2'd1) |=>
      ($stable(outq) && $stable(dir) && $stable(polq) && $stable(mask) && $stable(pen)));

  p_input_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_size == 2'd1 && bus_addr == AW'('h00)) |=>
      ($stable(outq) && $stable(dir) && $stable(polq) && $stable(mask) && $stable(pen)));

  p_no_drive_on_inputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_en) == '0);

  p_idle_rdata_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write && bus_size == 2'd1) |-> bus_rdata == '0);
endmodule

bind gpio_edge16 gpio_edge16_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .pad_out(pad_out), .pad_en(pad_en), .irq(irq), .stat(stat_q),
  .dir(dir_q), .mask(mask_q), .outq(out_q), .polq(pol_q), .pen(pen_q)
);

// File: tb/test_gpio_edge16.sv
module test_gpio_edge16;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_valid = 0, bus_write = 0;
  logic [1:0]  bus_size = 2'd1;
  logic [7:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, pins = 0;
  logic [15:0] bus_rdata, pad_out, pad_en;
  logic        irq;
  int n_cmp = 0, n_bad = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  gpio_edge16 i_gpio_edge16 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pins), .pad_out(pad_out), .pad_en(pad_en),
    .irq(irq)
  );

  // behavioural reference
  logic [15:0] m_out, m_dir, m_pol, m_mask, m_stat, m_pen;
  logic [15:0] hist [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = '1; m_dir = '1; m_pol = '1; m_mask = '1; m_pen = '1; m_stat = 0;
      hist[0] = 0; hist[1] = 0; hist[2] = 0;
    end else begin
      logic [15:0] up, dn, newbits;
      bit ok_wr;
      up = hist[1] & ~hist[2];
      dn = ~hist[1] & hist[2];
      newbits = ((up & m_pol) | (dn & ~m_pol)) & m_dir & ~m_mask;
      ok_wr = bus_valid && bus_write && bus_size == 2'd1;
      if (ok_wr && bus_addr == 8'h14) m_stat = m_stat & ~bus_wdata;
      m_stat = m_stat | newbits;
      if (ok_wr) begin
        if (bus_addr == 8'h04) m_out = bus_wdata;
        if (bus_addr == 8'h08) m_dir = bus_wdata;
        if (bus_addr == 8'h0C) m_pol = bus_wdata;
        if (bus_addr == 8'h10) m_mask = bus_wdata;
        if (bus_addr == 8'h18) m_pen = bus_wdata;
      end
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = pins;
    end
  end

  function automatic logic [15:0] model_rd();
    if (!(bus_valid && !bus_write && bus_size == 2'd1)) return 0;
    case (bus_addr)
      8'h00: return hist[1] & m_pen;
      8'h04: return m_out;
      8'h08: return m_dir;
      8'h0C: return m_pol;
      8'h10: return m_mask;
      8'h14: return m_stat;
      8'h18: return m_pen;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      check("R6 pad_en", pad_en, ~m_dir);
      check("R6 pad_out", pad_out, m_out & ~m_dir);
      check("R5 irq", {15'b0, irq}, {15'b0, |m_stat});
      check("R1 rdata", bus_rdata, model_rd());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz = 2'd1);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_size = 2'd1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag,
                    input logic [1:0] sz = 2'd1);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_size = sz;
    #6 check(tag, bus_rdata, exp);
    @(negedge clk);
    bus_valid = 0; bus_size = 2'd1;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #4000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R7 reset state
    rd(8'h04, 16'hFFFF, "R7 out latch");
    rd(8'h08, 16'hFFFF, "R7 direction");
    rd(8'h0C, 16'hFFFF, "R7 polarity");
    rd(8'h10, 16'hFFFF, "R7 mask");
    rd(8'h18, 16'hFFFF, "R7 pin enable");
    rd(8'h14, 16'h0000, "R7 status");
    rd(8'h00, 16'h0000, "R7 inputs");
    check("R7 pad_en", pad_en, 16'h0000);
    check("R7 irq", {15'b0, irq}, 16'h0000);

    // R3 rising edge on pin 3
    wr(8'h10, 16'h0000);
    @(negedge clk) pins = 16'h0008;
    settle();
    rd(8'h14, 16'h0008, "R3 rising latch");
    check("R5 irq set", {15'b0, irq}, 16'h0001);
    // R4 clear
    wr(8'h14, 16'h0008);
    rd(8'h14, 16'h0000, "R4 clear");
    check("R5 irq cleared", {15'b0, irq}, 16'h0000);

    // R3 falling polarity on pin 5
    wr(8'h0C, 16'hFFDF);
    @(negedge clk) pins = pins | 16'h0020;
    settle();
    rd(8'h14, 16'h0000, "R3 rise ignored on falling pin");
    @(negedge clk) pins = pins & ~16'h0020;
    settle();
    rd(8'h14, 16'h0020, "R3 falling latch");
    wr(8'h14, 16'hFFFF);

    // R3 masked pin 7
    wr(8'h10, 16'h0080);
    @(negedge clk) pins = pins | 16'h0080;
    settle();
    rd(8'h14, 16'h0000, "R3 masked pin");

    // R6 pin 2 to output
    wr(8'h08, 16'hFFFB);
    check("R6 pad_en after dir", pad_en, 16'h0004);
    check("R6 pad_out after dir", pad_out, 16'h0004);
    @(negedge clk) pins = pins | 16'h0004;
    settle();
    rd(8'h14, 16'h0000, "R3 output pin no latch");
    wr(8'h04, 16'h0000);
    check("R6 pad_out cleared", pad_out, 16'h0000);

    // R8 wrong size
    wr(8'h08, 16'h0000, 2'd0);
    rd(8'h08, 16'hFFFB, "R8 byte write ignored");
    wr(8'h10, 16'hFFFF, 2'd2);
    rd(8'h10, 16'h0080, "R8 word write ignored");
    rd(8'h08, 16'h0000, "R8 word read zero", 2'd2);

    // R9 write to input register
    wr(8'h00, 16'h1234);
    rd(8'h00, 16'h008C, "R9 input write ignored");
    rd(8'h04, 16'h0000, "R9 out latch untouched");

    // R1 out of range
    wr(8'h20, 16'hAAAA);
    rd(8'h20, 16'h0000, "R1 out of range read");
    rd(8'h0C, 16'hFFDF, "R1 polarity readback");

    // R2 pin enable and latency
    wr(8'h18, 16'h00FF);
    @(negedge clk) pins = 16'hFFFF;
    settle();
    rd(8'h00, 16'h00FF, "R2 enable masking");
    wr(8'h18, 16'hFFFF);
    @(negedge clk) pins = 16'h0000;
    rd(8'h00, 16'hFFFF, "R2 one edge still old");
    rd(8'h00, 16'h0000, "R2 visible after two edges");
    wr(8'h14, 16'hFFFF);

    // random activity, model compared each cycle (R3, R4, R5)
    wr(8'h10, 16'h0000);
    wr(8'h0C, 16'h5A3C);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      pins = pins ^ (16'(1) << ($urandom % 16));
      if ($urandom % 4 == 0) begin
        bus_valid = 1; bus_write = 1; bus_size = 2'd1; bus_addr = 8'h14;
        bus_wdata = 16'($urandom);
      end else if ($urandom % 3 == 0) begin
        bus_valid = 1; bus_write = 0; bus_size = 2'd1; bus_addr = 8'h14;
      end else begin
        bus_valid = 0; bus_write = 0;
      end
    end
    @(negedge clk) bus_valid = 0;
    settle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule